// File: doc/BRIEF.md
# Pattern-Locked Frame Checker

This block sits on the receive side of a serial link test path and judges whether the incoming parallel words carry a known test pattern. It starts out hunting: it watches each accepted word for a start-of-packet character (on an 8B/10B link this is the comma byte) and compares nothing until it sees one. Once it has seen one, it locks on and checks every later accepted word against the next entry of an internal pattern ROM, one word per clock.

The pattern is an incrementing count, `PAT_BASE + k*PAT_STEP` taken modulo 2^`DATA_W`, and it is set by parameter. The ROM index wraps from its last entry back to entry 0, so tracking continues across back-to-back frames. The first word that differs from its entry ends the lock. The saturating error counter then steps by one and the checker returns to hunting. That mismatching word is consumed and is not rescanned as a start-of-packet.

Input words use valid/ready. The checker never applies back-pressure: `rx_ready` is low only while reset is held and during the first clock after it is released, and high from then on. A word is accepted on a rising clock edge when `rx_valid` and `rx_ready` are both high. Data offered while `rx_valid` is low is ignored.

Top module: `pfc_frame_checker`

## Requirements
- R1: While `rst_n` is low, `tracking` is 0, `err_count` is 0 and `rx_ready` is 0. One clock edge after reset is released, `rx_ready` goes to 1 and then stays at 1.
- R2: While hunting, an accepted word that is not the start-of-packet character leaves `err_count` and `tracking` unchanged.
- R3: An accepted word whose bits selected by `SOP_MASK` equal those of `SOP_WORD` (default 8'hBC, all bits compared) while hunting makes `tracking` 1 after that clock edge.
- R4: The k-th accepted word after start-of-packet (k = 0, 1, ...) is expected to equal `(PAT_BASE + (k mod PAT_LEN)*PAT_STEP) mod 2^DATA_W`. When it matches, `tracking` stays 1 and `err_count` is unchanged.
- R5: On the first accepted word that differs from its expected value, `err_count` rises by exactly one and `tracking` is 0 after that clock edge.
- R6: `err_count` saturates at 2^`CNT_W`-1 and never wraps or decreases.
- R7: A cycle with `rx_valid` low changes neither `tracking`, `err_count` nor the pattern position, whatever `rx_data` holds.
- R8: After the word for entry `PAT_LEN`-1, the next accepted word is compared against entry 0, with no new start-of-packet needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Word on `rx_data` is offered |
| rx_ready | output | 1 | Checker accepts words (high once out of reset) |
| rx_data | input | DATA_W | Received parallel word |
| err_count | output | CNT_W | Saturating count of mismatches |
| tracking | output | 1 | 1 while locked and comparing, 0 while hunting |

## Verification
A wrong internal pattern position has no status pin of its own. It shows up on the very next accepted in-frame word as a false error: `err_count` steps and `tracking` drops one clock after that word. A stuck state machine shows in a different way. Either `tracking` stays low after a start-of-packet, or it stays high after a corrupt word, and both show one edge after the word in question. Gap cycles with garbage data, wrap-around frames and a long run of errors push the hidden index, the lock state and the counter limit into states where any slip reaches the ports within one accepted word.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } pfc_state_e;

  // Value of the counting pattern at position idx, before truncation.
  function automatic int unsigned pat_value(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned idx);
    return base + idx * step;
  endfunction

endpackage

// File: rtl/pfc_sop_detect.sv
module pfc_sop_detect #(
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-1:0] SOP_WORD = 8'hBC,
  parameter logic [DATA_W-1:0] SOP_MASK = 8'hFF
) (
  input  logic [DATA_W-1:0] data,
  output logic              hit
);

  localparam logic [DATA_W-1:0] SOP_KEY = SOP_WORD & SOP_MASK;

  always_comb begin
    hit = ((data & SOP_MASK) == SOP_KEY);
  end

endmodule

// File: rtl/pfc_pattern_rom.sv
module pfc_pattern_rom #(
  parameter int          DATA_W   = 8,
  parameter int          PAT_LEN  = 16,
  parameter int unsigned PAT_BASE = 0,
  parameter int unsigned PAT_STEP = 1,
  localparam int         AW       = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1
) (
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] rom [PAT_LEN];

  for (genvar gi = 0; gi < PAT_LEN; gi++) begin : g_entry
    localparam int unsigned RAW = pfc_pkg::pat_value(PAT_BASE, PAT_STEP, gi);
    assign rom[gi] = DATA_W'(RAW);
  end

  always_comb begin
    word = rom[addr];
  end

endmodule

// File: rtl/pfc_tracker.sv
module pfc_tracker #(
  parameter int DATA_W  = 8,
  parameter int PAT_LEN = 16,
  localparam int AW     = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              sop_hit,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] exp_word,
  output logic [AW-1:0]     addr,
  output logic              tracking,
  output logic              err_pulse
);

  import pfc_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(PAT_LEN - 1);

  pfc_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              err_d;
  logic              word_ok;
  logic [AW-1:0]     addr_next;

  assign word_ok   = (data == exp_word);
  assign addr_next = (addr_q == LAST) ? '0 : addr_q + AW'(1);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    err_d   = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_HUNT: begin
          if (sop_hit) begin
            state_d = ST_TRACK;
            addr_d  = '0;
          end
        end
        ST_TRACK: begin
          if (word_ok) begin
            addr_d = addr_next;
          end else begin
            state_d = ST_HUNT;
            addr_d  = '0;
            err_d   = 1'b1;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign addr      = addr_q;
  assign tracking  = (state_q == ST_TRACK);
  assign err_pulse = err_d;

endmodule

// File: rtl/pfc_err_counter.sv
module pfc_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (inc && (count_q != CNT_MAX)) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign count = count_q;

endmodule

// File: rtl/pfc_frame_checker.sv
module pfc_frame_checker #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] SOP_WORD = 8'hBC,
  parameter logic [DATA_W-1:0] SOP_MASK = 8'hFF,
  parameter int                PAT_LEN  = 16,
  parameter int unsigned       PAT_BASE = 0,
  parameter int unsigned       PAT_STEP = 1,
  parameter int                CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic [CNT_W-1:0]  err_count,
  output logic              tracking
);

  localparam int AW = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;

  logic              ready_q;
  logic              accept;
  logic              sop_hit;
  logic [AW-1:0]     rom_addr;
  logic [DATA_W-1:0] exp_word;
  logic              err_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign rx_ready = ready_q;
  assign accept   = rx_valid && ready_q;

  pfc_sop_detect #(
    .DATA_W   (DATA_W),
    .SOP_WORD (SOP_WORD),
    .SOP_MASK (SOP_MASK)
  ) u_sop (
    .data (rx_data),
    .hit  (sop_hit)
  );

  pfc_pattern_rom #(
    .DATA_W   (DATA_W),
    .PAT_LEN  (PAT_LEN),
    .PAT_BASE (PAT_BASE),
    .PAT_STEP (PAT_STEP)
  ) u_rom (
    .addr (rom_addr),
    .word (exp_word)
  );

  pfc_tracker #(
    .DATA_W  (DATA_W),
    .PAT_LEN (PAT_LEN)
  ) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .sop_hit   (sop_hit),
    .data      (rx_data),
    .exp_word  (exp_word),
    .addr      (rom_addr),
    .tracking  (tracking),
    .err_pulse (err_pulse)
  );

  pfc_err_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_pulse),
    .count (err_count)
  );

endmodule

// File: rtl/pfc_frame_checker_chk.sv
module pfc_frame_checker_chk #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] SOP_WORD = 8'hBC,
  parameter logic [DATA_W-1:0] SOP_MASK = 8'hFF,
  parameter int                CNT_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic [CNT_W-1:0]  err_count,
  input logic              tracking
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic sop_seen;
  assign sop_seen = ((rx_data & SOP_MASK) == (SOP_WORD & SOP_MASK));

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rx_ready); // R1

  AST_HUNT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !tracking |=> $stable(err_count)); // R2

  AST_SOP_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tracking && rx_valid && rx_ready && sop_seen) |=> tracking); // R3

  AST_ERR_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && err_count != CMAX) ##1 (err_count != $past(err_count)) |-> !tracking); // R5

  AST_ERR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != CMAX) |=> (err_count == $past(err_count) || err_count == $past(err_count) + CNT_W'(1))); // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CMAX) |=> (err_count == CMAX)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(tracking) && $stable(err_count))); // R7

endmodule

bind pfc_frame_checker pfc_frame_checker_chk #(
  .DATA_W   (DATA_W),
  .SOP_WORD (SOP_WORD),
  .SOP_MASK (SOP_MASK),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .err_count (err_count),
  .tracking  (tracking)
);

// File: tb/pfc_frame_checker_tb.sv
`timescale 1ns/1ps
module pfc_frame_checker_tb;

  localparam int          DW    = 8;
  localparam logic [7:0]  SOP   = 8'hBC;
  localparam int          LEN   = 16;
  localparam int unsigned BASE  = 0;
  localparam int unsigned STEP  = 1;
  localparam int          CW    = 8;
  localparam int          CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [DW-1:0] rx_data = '0;
  logic [CW-1:0] err_count;
  logic          tracking;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit m_track = 1'b0;
  int m_idx = 0;
  int m_err = 0;

  always #4 clk = ~clk;  // 125 MHz

  pfc_frame_checker #(
    .DATA_W (DW), .SOP_WORD (SOP), .SOP_MASK (8'hFF),
    .PAT_LEN (LEN), .PAT_BASE (BASE), .PAT_STEP (STEP), .CNT_W (CW)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_ready (rx_ready),
    .rx_data (rx_data), .err_count (err_count), .tracking (tracking)
  );

  function automatic logic [7:0] exp_word(input int k);
    return 8'((BASE + (k % LEN) * STEP) & 32'hFF);
  endfunction

  task automatic check(input string tag, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // At a negedge: drive one word, predict, wait one cycle, compare at next negedge.
  task automatic send(input bit v, input logic [7:0] d, input string tag);
    rx_valid = v;
    rx_data  = d;
    if (v) begin
      if (!m_track) begin
        if (d == SOP) begin m_track = 1'b1; m_idx = 0; end
      end else if (d == exp_word(m_idx)) begin
        m_idx = (m_idx + 1) % LEN;
      end else begin
        m_track = 1'b0;
        if (m_err < CMAX) m_err++;
      end
    end
    @(negedge clk);
    check(tag, int'(tracking), int'(m_track), "tracking");
    check(tag, int'(err_count), m_err, "err_count");
  endtask

  function automatic logic [7:0] non_sop(input logic [7:0] d);
    return (d == SOP) ? 8'h11 : d;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(rx_ready), 0, "ready in reset");
    check("R1", int'(tracking), 0, "tracking in reset");
    check("R1", int'(err_count), 0, "count in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(rx_ready), 1, "ready after reset");

    // R2: hunting ignores non-SOP words, including pattern words
    for (int i = 0; i < 20; i++) send(1'b1, non_sop(8'($urandom)), "R2");
    send(1'b1, exp_word(0), "R2");

    // R3 + R4 + R8: lock then run past the wrap
    send(1'b1, SOP, "R3");
    for (int k = 0; k < LEN + 6; k++) send(1'b1, exp_word(k), (k < LEN) ? "R4" : "R8");

    // R7: gaps with garbage (including a wrong word and SOP) do not advance or fail
    send(1'b0, 8'hFF, "R7");
    send(1'b0, SOP, "R7");
    send(1'b0, 8'h5A, "R7");
    send(1'b1, exp_word(LEN + 6), "R7");
    check("R7", int'(tracking), 1, "still locked after gap");

    // R5: mismatch drops lock and counts once
    send(1'b1, exp_word(m_idx) ^ 8'h04, "R5");
    check("R5", int'(err_count), 1, "first error");
    // R2: after the error, pattern words without SOP do not count
    send(1'b1, exp_word(0), "R2");
    send(1'b1, exp_word(1), "R2");
    // R3: mismatch immediately after SOP
    send(1'b1, SOP, "R3");
    send(1'b1, exp_word(0) ^ 8'h80, "R5");

    // random frames with gaps and occasional corruption
    for (int f = 0; f < 120; f++) begin
      int flen;
      flen = 1 + int'($urandom % 40);
      send(1'b1, SOP, "R3");
      for (int k = 0; k < flen; k++) begin
        logic [7:0] w;
        if (($urandom % 4) == 0) send(1'b0, 8'($urandom), "R7");
        w = exp_word(m_idx);
        if (($urandom % 32) == 0) w = w ^ 8'(1 + ($urandom % 255));
        send(1'b1, w, "R4");
      end
      for (int g = 0; g < int'($urandom % 3); g++) send(1'b1, non_sop(8'($urandom)), "R2");
    end

    // R6: drive the counter to its limit and beyond
    while (m_err < CMAX + 4) begin
      send(1'b1, SOP, "R6");
      send(1'b1, exp_word(0) ^ 8'h01, "R6");
      if (m_err == CMAX) break;
    end
    for (int i = 0; i < 4; i++) begin
      send(1'b1, SOP, "R6");
      send(1'b1, exp_word(0) ^ 8'h01, "R6");
    end
    check("R6", int'(err_count), CMAX, "saturated count");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule